// File: doc/BRIEF.md
# Ethernet Address Hash Filter

This block is a first-stage receive address filter. It decides whether a frame may be passed on, based only on the frame's 48-bit destination address. The address is run through a serial 32-bit CRC. Six bits of the result name one of 64 bins, and each bin is a single bit in a hash table. Two separate 64-bit tables are kept, one for group (multicast) destinations and one for individual destinations. Each table is held as four 16-bit registers.

One command port serves two purposes. In program mode it hashes the supplied address and sets the bin that the address maps to. In lookup mode it hashes the address and reports accept or reject from the table that matches the address type. A synchronous clear input empties both tables. A register select input reads any of the eight 16-bit table registers back.

Top module: `eth_hash_filter`

## Requirements
- R1: After reset, all eight table registers read zero, and `busy_o`, `done_o` and `accept_o` are low.
- R2: The hash starts from a CRC register preset to all ones and uses polynomial 0x04C11DB7. The shift register moves toward bit 31, and the feedback is bit 31 XOR the input bit. Address bits enter one per clock, octet `addr_i[47:40]` first, and inside each octet the least significant bit comes first.
- R3: A command is taken when `cmd_valid_i` is high while the block is idle. `busy_o` then stays high for exactly 48 cycles. `cmd_valid_i` has no effect while `busy_o` or `done_o` is high.
- R4: `done_o` is high for exactly one cycle, in the cycle right after `busy_o` falls, and it is never high together with `busy_o`.
- R5: A program command (`cmd_set_i`=1) sets one bit. After the command, the register chosen by CRC bits 31:30 has the bit chosen by CRC bits 29:26 set, in the group table when `addr_i[40]`=1 and in the individual table otherwise. No other bit of either table changes.
- R6: A lookup command (`cmd_set_i`=0) gives `accept_o`=1 in its `done_o` cycle when the selected bin is set, and 0 when it is clear. Only the table picked by `addr_i[40]` is consulted.
- R7: A cycle with `clear_i` high zeroes both tables at that clock edge. Every lookup after that rejects until bins are programmed again.
- R8: `rd_data_o` shows a table register with no delay. `rd_sel_i[2]` selects the group table (1) or the individual table (0). `rd_sel_i[1:0]` gives the register number. Bin n of a table is bit n%16 of register n/16.
- R9: `accept_o` is low in every cycle except the `done_o` cycle of a lookup whose bin is set. It stays low for program commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 48 | Destination address; bits 47:40 are the first octet |
| cmd_valid_i | input | 1 | Start a command (taken only when idle) |
| cmd_set_i | input | 1 | 1 = program the bin, 0 = lookup |
| clear_i | input | 1 | Zero both tables |
| rd_sel_i | input | 3 | Read-back select: table in bit 2, register in bits 1:0 |
| rd_data_o | output | 16 | Selected table register |
| busy_o | output | 1 | Hash in progress |
| done_o | output | 1 | One-cycle completion pulse |
| accept_o | output | 1 | Lookup result, valid with done_o |

## Verification
If a command is taken at clock edge T, `busy_o` is high in the 48 cycles after it. `done_o` and a lookup's `accept_o` are due in the cycle after edge T+48. A programmed bit shows on `rd_data_o` after edge T+49, and a clear shows after the edge that samples it. The bench drives inputs and samples outputs on falling edges. It counts the `busy_o` cycles one falling edge at a time and reads the result in the exact falling edge that follows them. Table contents are compared only after the `done_o` cycle has passed. Expected bins come from a bytewise CRC model in the bench. That model is checked against the tables after each of many program commands with mixed address types, against lookups of random and programmed addresses, against a lookup whose bin is set only in the other table, and against a command issued while busy.

// File: rtl/eth_hash_pkg.sv
// Package: shared constants and types for the address hash filter.
// Assumes: a single clock domain; the constants are the defaults used by the top.
package eth_hash_pkg;

    // CRC-32 generator polynomial (bit 32 implied)
    localparam logic [31:0] HASH_POLY = 32'h04C1_1DB7;

    // Command sequencer states
    typedef enum logic [1:0] {
        HF_IDLE  = 2'd0,
        HF_SHIFT = 2'd1,
        HF_DONE  = 2'd2
    } hf_state_e;

endpackage

// File: rtl/eth_hash_crc.sv
// Module: serial CRC engine that turns an address into a bin number.
// On start_i it latches the address in transmit bit order: first octet first,
// and least significant bit first inside each octet. It presets the CRC to
// all ones and then folds in one bit per clock for ADDR_W clocks. hash_o holds
// the top HASH_W bits of the CRC register.
// Assumes: ADDR_W is a multiple of 8, and start_i is not raised while running.
module eth_hash_crc #(
    parameter int ADDR_W = 48,
    parameter int CRC_W  = 32,
    parameter logic [CRC_W-1:0] POLY = 32'h04C1_1DB7,
    parameter int HASH_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              last_o,
    output logic [HASH_W-1:0] hash_o
);

    localparam int CNT_W = $clog2(ADDR_W);

    logic [ADDR_W-1:0] ser_w;
    logic [ADDR_W-1:0] ser_q;
    logic [CRC_W-1:0]  crc_q;
    logic [CRC_W-1:0]  crc_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              run_q;
    logic              fb_w;

    // Reorder the address so that bit 0 is the first bit to be hashed
    generate
        for (genvar k = 0; k < ADDR_W; k++) begin : g_order
            assign ser_w[k] = addr_i[ADDR_W - 8 - 8 * (k / 8) + (k % 8)];
        end
    endgenerate

    // One CRC step: shift toward the MSB and fold in the polynomial on feedback
    always_comb begin
        fb_w  = crc_q[CRC_W-1] ^ ser_q[0];
        crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb_w ? POLY : '0);
    end

    // Shift sequencer: load on start, then one address bit per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            crc_q <= '1;
            ser_q <= '0;
        end else if (start_i) begin
            run_q <= 1'b1;
            cnt_q <= '0;
            crc_q <= '1;
            ser_q <= ser_w;
        end else if (run_q) begin
            crc_q <= crc_d;
            ser_q <= ser_q >> 1;
            cnt_q <= cnt_q + 1'b1;
            if (last_o) begin
                run_q <= 1'b0;
            end
        end
    end

    // Flag the step that folds in the final address bit
    assign last_o = run_q && (cnt_q == CNT_W'(ADDR_W - 1));

    // Bin bits: register index on top, bit index below it
    assign hash_o = crc_q[CRC_W-1 -: HASH_W];

endmodule

// File: rtl/eth_hash_tables.sv
// Module: the two hash tables (index 0 = individual, 1 = group).
// Each table is NUM_REGS registers of REG_W bits. A write sets one bin and
// leaves the others alone. Clear zeroes both tables and wins over a write in
// the same cycle. The lookup and the read-back are combinational.
// Assumes: REG_W and NUM_REGS are powers of two.
module eth_hash_tables #(
    parameter int REG_W    = 16,
    parameter int NUM_REGS = 4,
    localparam int REG_IDX_W = $clog2(NUM_REGS),
    localparam int BIT_IDX_W = $clog2(REG_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 wr_i,
    input  logic                 grp_i,
    input  logic [REG_IDX_W-1:0] reg_i,
    input  logic [BIT_IDX_W-1:0] bit_i,
    input  logic [REG_IDX_W:0]   rd_sel_i,
    output logic                 hit_o,
    output logic [REG_W-1:0]     rd_data_o
);

    localparam int TBL_W = REG_W * NUM_REGS;
    localparam int BIN_W = REG_IDX_W + BIT_IDX_W;

    logic [BIN_W-1:0]         bin_w;
    logic [1:0]               hit_w;
    logic [1:0][REG_W-1:0]    rd_w;

    // Flat bin number inside a table
    assign bin_w = {reg_i, bit_i};

    generate
        for (genvar t = 0; t < 2; t++) begin : g_tbl
            logic [TBL_W-1:0] bits_q;

            // Table storage: clear wins, otherwise OR in the addressed bin
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bits_q <= '0;
                end else if (clear_i) begin
                    bits_q <= '0;
                end else if (wr_i && (grp_i == 1'(t))) begin
                    bits_q[bin_w] <= 1'b1;
                end
            end

            assign hit_w[t] = bits_q[bin_w];
            assign rd_w[t]  = bits_q[rd_sel_i[REG_IDX_W-1:0] * REG_W +: REG_W];
        end
    endgenerate

    // Consult only the table that matches the address type
    assign hit_o     = hit_w[grp_i];
    assign rd_data_o = rd_w[rd_sel_i[REG_IDX_W]];

endmodule

// File: rtl/eth_hash_filter.sv
// Module: top of the address hash filter.
// It takes a program or lookup command while idle, hashes the address over
// ADDR_W clocks, and then spends one done cycle. In that cycle a lookup
// reports accept, and a program command sets its bin at the closing edge.
// The address type is the I/G bit, which is the LSB of the first octet.
// Assumes: addr_i and cmd_set_i are valid in the cycle cmd_valid_i is taken.
module eth_hash_filter #(
    parameter int ADDR_W   = 48,
    parameter int CRC_W    = 32,
    parameter logic [CRC_W-1:0] POLY = eth_hash_pkg::HASH_POLY,
    parameter int REG_W    = 16,
    parameter int NUM_REGS = 4,
    localparam int REG_IDX_W = $clog2(NUM_REGS),
    localparam int BIT_IDX_W = $clog2(REG_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cmd_valid_i,
    input  logic              cmd_set_i,
    input  logic              clear_i,
    input  logic [REG_IDX_W:0] rd_sel_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              accept_o
);

    import eth_hash_pkg::*;

    localparam int HASH_W = REG_IDX_W + BIT_IDX_W;
    localparam int IG_POS = ADDR_W - 8;

    hf_state_e            state_q;
    logic                 grp_q;
    logic                 set_q;
    logic                 start_w;
    logic                 last_w;
    logic                 hit_w;
    logic [HASH_W-1:0]    hash_w;

    assign start_w = (state_q == HF_IDLE) && cmd_valid_i;

    // Command sequencer: idle -> hashing -> one done cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HF_IDLE;
            grp_q   <= 1'b0;
            set_q   <= 1'b0;
        end else begin
            case (state_q)
                HF_IDLE: begin
                    if (cmd_valid_i) begin
                        state_q <= HF_SHIFT;
                        grp_q   <= addr_i[IG_POS];
                        set_q   <= cmd_set_i;
                    end
                end
                HF_SHIFT: begin
                    if (last_w) begin
                        state_q <= HF_DONE;
                    end
                end
                default: state_q <= HF_IDLE;
            endcase
        end
    end

    eth_hash_crc #(
        .ADDR_W (ADDR_W),
        .CRC_W  (CRC_W),
        .POLY   (POLY),
        .HASH_W (HASH_W)
    ) crc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_w),
        .addr_i  (addr_i),
        .last_o  (last_w),
        .hash_o  (hash_w)
    );

    eth_hash_tables #(
        .REG_W    (REG_W),
        .NUM_REGS (NUM_REGS)
    ) tables_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_i),
        .wr_i      (done_o && set_q),
        .grp_i     (grp_q),
        .reg_i     (hash_w[HASH_W-1 -: REG_IDX_W]),
        .bit_i     (hash_w[BIT_IDX_W-1:0]),
        .rd_sel_i  (rd_sel_i),
        .hit_o     (hit_w),
        .rd_data_o (rd_data_o)
    );

    // Status and result outputs
    assign busy_o   = (state_q == HF_SHIFT);
    assign done_o   = (state_q == HF_DONE);
    assign accept_o = done_o && !set_q && hit_w;

endmodule

// File: rtl/eth_hash_filter_chk.sv
// Module: protocol checker for eth_hash_filter, attached with bind.
// It watches only ports. It counts busy cycles so that the hash length can be
// checked without a deep $past.
module eth_hash_filter_chk #(
    parameter int ADDR_W = 48,
    parameter int REG_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid_i,
    input logic             clear_i,
    input logic [2:0]       rd_sel_i,
    input logic [REG_W-1:0] rd_data_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             accept_o
);

    localparam int BC_W = $clog2(ADDR_W) + 2;
    logic [BC_W-1:0] busy_cnt_q;

    // Length of the current busy stretch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt_q <= '0;
        end else if (busy_o) begin
            busy_cnt_q <= busy_cnt_q + 1'b1;
        end else begin
            busy_cnt_q <= '0;
        end
    end

    assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !done_o && cmd_valid_i) |=> busy_o);

    assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_cnt_q == BC_W'(ADDR_W)));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    assert_busy_done_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    assert_no_bit_lost_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clear_i) && $stable(rd_sel_i)) |->
            ((rd_data_o & $past(rd_data_o)) == $past(rd_data_o)));

    assert_clear_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear_i) |-> (rd_data_o == '0));

    assert_accept_in_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> done_o);

endmodule

bind eth_hash_filter eth_hash_filter_chk #(
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid_i),
    .clear_i     (clear_i),
    .rd_sel_i    (rd_sel_i),
    .rd_data_o   (rd_data_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .accept_o    (accept_o)
);

// File: tb/eth_hash_filter_tb_top.sv
// Bench: sweeps of program and lookup commands against a bytewise CRC model.
`timescale 1ns/100ps
module eth_hash_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] addr_i = '0;
    logic        cmd_valid_i = 1'b0;
    logic        cmd_set_i = 1'b0;
    logic        clear_i = 1'b0;
    logic [2:0]  rd_sel_i = '0;
    logic [15:0] rd_data_o;
    logic        busy_o;
    logic        done_o;
    logic        accept_o;

    int          n_checks = 0;
    int          n_fails = 0;
    logic [63:0] m_tbl [2];

    always #4 clk = ~clk;

    eth_hash_filter dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (addr_i),
        .cmd_valid_i (cmd_valid_i),
        .cmd_set_i   (cmd_set_i),
        .clear_i     (clear_i),
        .rd_sel_i    (rd_sel_i),
        .rd_data_o   (rd_data_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .accept_o    (accept_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Bin model (R2): CRC preset ones, LSB first per octet, first octet first
    function automatic logic [5:0] model_bin(input logic [47:0] a);
        logic [31:0] c = '1;
        for (int o = 0; o < 6; o++) begin
            logic [7:0] oct = a[47 - 8 * o -: 8];
            for (int b = 0; b < 8; b++) begin
                logic fb = c[31] ^ oct[b];
                c = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        end
        return c[31:26];
    endfunction

    function automatic logic [47:0] rnd_addr(input bit grp);
        logic [47:0] a = {$urandom(), $urandom()};
        a[40] = grp;
        return a;
    endfunction

    // Issue one command and check its timing; optionally poke cmd_valid while busy
    task automatic run_op(input logic [47:0] a, input bit set, input bit poke,
                          output bit acc);
        int nb = 0;
        @(negedge clk);
        addr_i = a; cmd_set_i = set; cmd_valid_i = 1'b1;
        @(negedge clk);
        cmd_valid_i = 1'b0;
        while (busy_o && nb < 200) begin
            nb++;
            if (poke && nb == 10) begin
                cmd_valid_i = 1'b1; cmd_set_i = 1'b1; addr_i = ~a;
            end else begin
                cmd_valid_i = 1'b0;
            end
            @(negedge clk);
        end
        cmd_valid_i = 1'b0;
        check(nb == 48, "R3", "busy cycles", 64'(nb), 64'd48);
        check(done_o == 1'b1, "R4", "done after busy", 64'(done_o), 64'd1);
        acc = accept_o;
        if (set) check(acc == 1'b0, "R9", "accept on program", 64'(acc), 64'd0);
        @(negedge clk);
        check(done_o == 1'b0, "R4", "done width", 64'(done_o), 64'd0);
        check(accept_o == 1'b0, "R9", "accept outside done", 64'(accept_o), 64'd0);
        if (set) m_tbl[a[40]][model_bin(a)] = 1'b1;
    endtask

    // Compare all eight registers with the model (R8 mapping)
    task automatic check_tables(input string req);
        for (int s = 0; s < 8; s++) begin
            logic [2:0]  sel = 3'(s);
            logic [15:0] exp = m_tbl[sel[2]][sel[1:0] * 16 +: 16];
            rd_sel_i = sel;
            #0.2;
            check(rd_data_o == exp, req, "table register", 64'(rd_data_o), 64'(exp));
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        m_tbl[0] = '0;
        m_tbl[1] = '0;
    endtask

    task automatic lookup_check(input logic [47:0] a, input string req);
        bit acc;
        logic exp = m_tbl[a[40]][model_bin(a)];
        run_op(a, 1'b0, 1'b0, acc);
        check(acc == exp, req, "lookup result", 64'(acc), 64'(exp));
    endtask

    logic [47:0] prog_list [40];

    initial begin
        bit acc;
        m_tbl[0] = '0;
        m_tbl[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(busy_o == 1'b0, "R1", "busy after reset", 64'(busy_o), 64'd0);
        check(done_o == 1'b0, "R1", "done after reset", 64'(done_o), 64'd0);
        check(accept_o == 1'b0, "R1", "accept after reset", 64'(accept_o), 64'd0);
        check_tables("R1");

        // R7: empty tables reject everything
        for (int i = 0; i < 16; i++) lookup_check(rnd_addr(1'(i)), "R7");

        // R5/R2/R8: program mixed-type addresses, tables follow the model
        for (int i = 0; i < 40; i++) begin
            prog_list[i] = rnd_addr(1'(i % 3 == 0));
            run_op(prog_list[i], 1'b1, 1'b0, acc);
            check_tables("R5");
        end

        // R6: programmed addresses accept, random ones follow the model
        for (int i = 0; i < 40; i++) lookup_check(prog_list[i], "R6");
        for (int i = 0; i < 120; i++) lookup_check(rnd_addr(1'($urandom() % 2)), "R2");

        // R6: bin set only in the group table must not accept an individual address
        do_clear();
        begin
            logic [47:0] g = rnd_addr(1'b1);
            logic [47:0] x = '0;
            bit found = 1'b0;
            run_op(g, 1'b1, 1'b0, acc);
            for (int t = 0; t < 20000 && !found; t++) begin
                x = rnd_addr(1'b0);
                if (model_bin(x) == model_bin(g)) found = 1'b1;
            end
            check(found, "R6", "search for same-bin address", 64'(found), 64'd1);
            lookup_check(x, "R6");
            lookup_check(g, "R6");
            x[40] = 1'b1;
            lookup_check(x, "R6");
        end

        // R3: a command raised while busy is ignored
        do_clear();
        begin
            logic [47:0] p = rnd_addr(1'b0);
            run_op(p, 1'b1, 1'b1, acc);
            check(busy_o == 1'b0, "R3", "no second command", 64'(busy_o), 64'd0);
            check_tables("R3");
        end

        // R7: clear empties tables and later lookups reject
        for (int i = 0; i < 10; i++) run_op(prog_list[i], 1'b1, 1'b0, acc);
        check_tables("R5");
        do_clear();
        check_tables("R7");
        for (int i = 0; i < 10; i++) lookup_check(prog_list[i], "R7");

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule